// File: doc/BRIEF.md
# Memory Address Router with Segment Shadowing

This block sorts every memory transaction into one of four destinations: local DRAM, general PCI memory, the firmware ROM window just below 4 GB, or the register window of the I/O interrupt controller. Each transaction brings an address, a direction flag and a flag that says whether it came from the processor or from a PCI/ISA master. One cycle later the block returns a one-hot destination select and a suppress flag. The suppress flag tells the bus bridge to keep the transaction off the processor bus.

The legacy expansion area from 0xC0000 to 0xFFFFF is split into 16 KB segments. Each segment has a read attribute bit and a write attribute bit, so reads and writes to the same address can be steered independently to ROM or to RAM. Firmware uses this to copy ROM code into RAM and then run it from RAM. The top of DRAM comes from an input in 1 MB units and is clamped to a parameterised maximum. A mode register can also clamp it to 256 MB when extended SMRAM is in use, and can open a 1 MB hole at 15 MB that is routed to PCI.

Top module: `memmap_router`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. While `out_valid` is high, exactly one bit of `out_tgt` is set. While it is low, `out_tgt` and `out_suppress` are zero. Bit 0 of `out_tgt` is DRAM, bit 1 is PCI memory, bit 2 is firmware ROM and bit 3 is the interrupt-controller window.
- R2: An address decodes to DRAM when it is below the effective top of memory, or when it lies below 1 MB outside the shadow area. Any other address that no fixed window claims decodes to PCI memory, both below and above 4 GB.
- R3: `top_mb` gives the top of DRAM in 1 MB units. A value above MAX_TOP_MB (12288, which is 12 GB) acts as MAX_TOP_MB.
- R4: When mode bit 1 (extended SMRAM) is set, the effective top is the smaller of the clamped top and 256 MB.
- R5: When mode bit 0 (hole enable) is set, addresses from 15 MB up to 16 MB decode to PCI memory, even if they lie below the top of memory.
- R6: Addresses in the top 2 MB below 4 GB decode to firmware ROM, whatever the top of memory.
- R7: A 64 KB window that starts 20 MB below 4 GB decodes to the interrupt-controller target, whatever the top of memory.
- R8: The area 0xC0000 to 0xFFFFF holds 16 segments of 16 KB. Segment i uses attribute bits [2i+1:2i]. Bit 2i set sends reads to DRAM and clear sends them to ROM. Bit 2i+1 does the same for writes. So 00 sends both to ROM, 01 reads from RAM and writes to ROM, 10 reads from ROM and writes to RAM, and 11 sends both to RAM.
- R9: `out_suppress` is high for a valid transaction from a PCI/ISA master (`in_from_pci`=1) that hits a segment whose attribute is not 00. It is low for processor transactions and for unshadowed segments.
- R10: A write with `cfg_we`=1 loads the attributes when `cfg_sel`=0, and loads mode bits [1:0] from `cfg_wdata` when `cfg_sel`=1. The new value applies from the next clock on. A transaction in the same cycle still sees the old value. After reset the attributes are all 00 and both mode bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A transaction is presented this cycle |
| in_addr | input | ADDR_W (36) | Byte address of the transaction |
| in_write | input | 1 | 1 = write, 0 = read |
| in_from_pci | input | 1 | 1 = issued by a PCI/ISA master, 0 = issued by the processor |
| top_mb | input | ADDR_W-20 (16) | Top of DRAM in 1 MB units |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = attribute register, 1 = mode register |
| cfg_wdata | input | 2*SHADOW_SEGS (32) | Configuration write data |
| out_valid | output | 1 | Decode result is valid |
| out_tgt | output | 4 | One-hot destination select |
| out_suppress | output | 1 | Keep this transaction off the processor bus |

## Verification
The bench builds the block with its default parameters: 36-bit addresses, sixteen 16 KB segments and a 12 GB maximum top. The 36-bit width lets the bench place addresses above 4 GB and push `top_mb` past the clamp. That covers the DRAM/PCI boundary on both sides of 4 GB and the cases where the clamp and the SMRAM limit decide the result. With sixteen segments the whole attribute register is used, including the first and last segments at the edges of the shadow area. A random phase then mixes attribute and mode rewrites with addresses drawn near every window edge.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [1:0] {
      TGT_DRAM   = 2'd0,
      TGT_PCI    = 2'd1,
      TGT_ROM    = 2'd2,
      TGT_IOAPIC = 2'd3
   } target_e;

   localparam int NUM_TARGETS = 4;
   localparam int MB_SHIFT    = 20;

endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs #(
   parameter int SHADOW_SEGS = 16,
   localparam int CFG_W = 2 * SHADOW_SEGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] attr,
   output logic             hole_en,
   output logic             smram_ext
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr      <= '0;
         hole_en   <= 1'b0;
         smram_ext <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel) begin
            hole_en   <= cfg_wdata[0];
            smram_ext <= cfg_wdata[1];
         end else begin
            attr <= cfg_wdata;
         end
      end
   end

   AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(attr) && $stable(hole_en) && $stable(smram_ext)); // R10

endmodule

// File: rtl/memmap_shadow_lookup.sv
module memmap_shadow_lookup #(
   parameter int          ADDR_W      = 36,
   parameter int          SHADOW_SEGS = 16,
   parameter int          SEG_SHIFT   = 14,
   parameter logic [63:0] SHADOW_BASE = 64'h000C_0000,
   localparam int CFG_W  = 2 * SHADOW_SEGS,
   localparam int IDX_W  = $clog2(SHADOW_SEGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   input  logic [CFG_W-1:0]  attr,
   output logic              in_region,
   output logic              to_ram,
   output logic              shadowed
);

   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(SHADOW_BASE);
   localparam logic [ADDR_W-1:0] LIMIT_A =
      ADDR_W'(SHADOW_BASE + (64'(SHADOW_SEGS) << SEG_SHIFT));

   logic [IDX_W-1:0]       seg_idx;
   logic [SHADOW_SEGS-1:0] seg_hit;
   logic [SHADOW_SEGS-1:0] rd_ram;
   logic [SHADOW_SEGS-1:0] wr_ram;

   assign in_region = (addr >= BASE_A) && (addr < LIMIT_A);
   assign seg_idx   = IDX_W'((addr - BASE_A) >> SEG_SHIFT);

   for (genvar s = 0; s < SHADOW_SEGS; s++) begin : g_seg
      assign seg_hit[s] = in_region && (seg_idx == IDX_W'(s));
      assign rd_ram[s]  = attr[2*s];
      assign wr_ram[s]  = attr[2*s+1];
   end

   assign to_ram   = is_write ? |(seg_hit & wr_ram) : |(seg_hit & rd_ram);
   assign shadowed = |(seg_hit & (rd_ram | wr_ram));

endmodule

// File: rtl/memmap_region_decode.sv
module memmap_region_decode
   import memmap_pkg::*;
#(
   parameter int ADDR_W         = 36,
   parameter int ROM_MB         = 2,
   parameter int APIC_BELOW_MB  = 20,
   parameter int APIC_BYTES     = 65536,
   parameter int HOLE_MB        = 15,
   localparam int TOP_W = ADDR_W - MB_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [TOP_W-1:0]  eff_top_mb,
   input  logic              hole_en,
   input  logic              shadow_hit,
   input  logic              shadow_to_ram,
   output target_e           tgt
);

   localparam logic [63:0]       FOUR_G_64 = 64'h1_0000_0000;
   localparam logic [ADDR_W-1:0] FOUR_G    = ADDR_W'(FOUR_G_64);
   localparam logic [ADDR_W-1:0] ROM_LO    = ADDR_W'(FOUR_G_64 - (64'(ROM_MB) << MB_SHIFT));
   localparam logic [ADDR_W-1:0] APIC_LO   = ADDR_W'(FOUR_G_64 - (64'(APIC_BELOW_MB) << MB_SHIFT));
   localparam logic [ADDR_W-1:0] APIC_HI   = ADDR_W'(FOUR_G_64 - (64'(APIC_BELOW_MB) << MB_SHIFT)
                                                   + 64'(APIC_BYTES));

   logic [TOP_W-1:0] addr_mb;
   logic             dram_hit;

   assign addr_mb  = addr[ADDR_W-1:MB_SHIFT];
   assign dram_hit = addr_mb < eff_top_mb;

   always_comb begin
      if (shadow_hit) begin
         tgt = shadow_to_ram ? TGT_DRAM : TGT_ROM;
      end else if (addr_mb == '0) begin
         tgt = TGT_DRAM;
      end else if (addr >= FOUR_G) begin
         tgt = dram_hit ? TGT_DRAM : TGT_PCI;
      end else if (addr >= ROM_LO) begin
         tgt = TGT_ROM;
      end else if (addr >= APIC_LO && addr < APIC_HI) begin
         tgt = TGT_IOAPIC;
      end else if (hole_en && addr_mb == TOP_W'(HOLE_MB)) begin
         tgt = TGT_PCI;
      end else begin
         tgt = dram_hit ? TGT_DRAM : TGT_PCI;
      end
   end

endmodule

// File: rtl/memmap_router.sv
module memmap_router
   import memmap_pkg::*;
#(
   parameter int ADDR_W       = 36,
   parameter int SHADOW_SEGS  = 16,
   parameter int SEG_SHIFT    = 14,
   parameter int MAX_TOP_MB   = 12288,
   parameter int SMRAM_TOP_MB = 256,
   parameter bit HOLE_SUPPORT = 1'b1,
   localparam int TOP_W = ADDR_W - MB_SHIFT,
   localparam int CFG_W = 2 * SHADOW_SEGS,
   localparam int NT    = NUM_TARGETS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_write,
   input  logic              in_from_pci,
   input  logic [TOP_W-1:0]  top_mb,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              out_valid,
   output logic [NT-1:0]     out_tgt,
   output logic              out_suppress
);

   // elaboration-time parameter checks
   if (ADDR_W < 33 || ADDR_W > 48) begin : g_bad_addr_w
      $error("memmap_router: ADDR_W must lie in 33..48");
   end
   if ((SHADOW_SEGS << SEG_SHIFT) != 32'h4_0000) begin : g_bad_shadow
      $error("memmap_router: shadow segments must cover exactly 256 KB");
   end
   if (MAX_TOP_MB >= (1 << TOP_W) || SMRAM_TOP_MB > MAX_TOP_MB) begin : g_bad_top
      $error("memmap_router: top-of-memory limits do not fit");
   end

   localparam logic [ADDR_W-1:0] FOUR_G  = ADDR_W'(64'h1_0000_0000);
   localparam logic [ADDR_W-1:0] ROM_LO  = ADDR_W'(64'h1_0000_0000 - 64'h20_0000);
   localparam logic [ADDR_W-1:0] APIC_LO = ADDR_W'(64'h1_0000_0000 - 64'h140_0000);
   localparam logic [ADDR_W-1:0] APIC_HI = ADDR_W'(64'h1_0000_0000 - 64'h140_0000 + 64'h1_0000);

   logic [CFG_W-1:0] attr;
   logic             hole_en;
   logic             hole_eff;
   logic             smram_ext;
   logic [TOP_W-1:0] top_clamped;
   logic [TOP_W-1:0] eff_top_mb;
   logic             sh_region;
   logic             sh_to_ram;
   logic             sh_shadowed;
   target_e          dec_tgt;

   memmap_cfg_regs #(.SHADOW_SEGS(SHADOW_SEGS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .attr      (attr),
      .hole_en   (hole_en),
      .smram_ext (smram_ext)
   );

   if (HOLE_SUPPORT) begin : g_hole
      assign hole_eff = hole_en;
   end else begin : g_no_hole
      assign hole_eff = 1'b0;
   end

   always_comb begin
      top_clamped = (top_mb > TOP_W'(MAX_TOP_MB)) ? TOP_W'(MAX_TOP_MB) : top_mb;
      eff_top_mb  = top_clamped;
      if (smram_ext && top_clamped > TOP_W'(SMRAM_TOP_MB)) begin
         eff_top_mb = TOP_W'(SMRAM_TOP_MB);
      end
   end

   memmap_shadow_lookup #(
      .ADDR_W      (ADDR_W),
      .SHADOW_SEGS (SHADOW_SEGS),
      .SEG_SHIFT   (SEG_SHIFT)
   ) u_shadow (
      .addr      (in_addr),
      .is_write  (in_write),
      .attr      (attr),
      .in_region (sh_region),
      .to_ram    (sh_to_ram),
      .shadowed  (sh_shadowed)
   );

   memmap_region_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr          (in_addr),
      .eff_top_mb    (eff_top_mb),
      .hole_en       (hole_eff),
      .shadow_hit    (sh_region),
      .shadow_to_ram (sh_to_ram),
      .tgt           (dec_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_tgt      <= '0;
         out_suppress <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         out_tgt      <= in_valid ? (NT'(1) << dec_tgt) : '0;
         out_suppress <= in_valid && in_from_pci && sh_shadowed;
      end
   end

   AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_tgt) == 1); // R1
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_tgt == '0) && !out_suppress); // R1
   AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_addr >= ROM_LO && in_addr < FOUR_G) |=> out_tgt[TGT_ROM]); // R6
   AST_APIC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_addr >= APIC_LO && in_addr < APIC_HI) |=> out_tgt[TGT_IOAPIC]); // R7
   AST_HOLE_PCI: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hole_eff && in_addr[ADDR_W-1:MB_SHIFT] == TOP_W'(15)) |=> out_tgt[TGT_PCI]); // R5
   AST_CPU_NOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_from_pci) |=> !out_suppress); // R9

endmodule

// File: tb/memmap_router_bench.sv
`timescale 1ns/1ps
module memmap_router_bench;

   localparam int AW   = 36;
   localparam int SEGS = 16;
   localparam int TW   = AW - 20;
   localparam int CW   = 2 * SEGS;
   localparam longint MB = 64'h10_0000;
   localparam longint GB = 64'h4000_0000;
   localparam longint G4 = 64'h1_0000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          in_write = 1'b0;
   logic          in_from_pci = 1'b0;
   logic [TW-1:0] top_mb = '0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [CW-1:0] cfg_wdata = '0;
   logic          out_valid;
   logic [3:0]    out_tgt;
   logic          out_suppress;

   always #2 clk = ~clk;

   memmap_router u_memmap_router (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_addr (in_addr),
      .in_write (in_write), .in_from_pci (in_from_pci), .top_mb (top_mb),
      .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
      .out_valid (out_valid), .out_tgt (out_tgt), .out_suppress (out_suppress)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference state
   bit [CW-1:0] m_attr = '0;
   bit          m_hole = 0;
   bit          m_smram = 0;
   bit          exp_v = 0;
   bit [3:0]    exp_tgt = '0;
   bit          exp_sup = 0;

   function automatic bit in_shadow(longint a);
      return (a >= 64'hC_0000) && (a < 64'h10_0000);
   endfunction

   // 0 DRAM, 1 PCI, 2 ROM, 3 interrupt controller
   function automatic int model_tgt(longint a, bit wr);
      longint eff;
      longint mbn;
      int seg;
      eff = longint'(top_mb);
      if (eff > 12288) eff = 12288;
      if (m_smram && eff > 256) eff = 256;
      mbn = a / MB;
      if (in_shadow(a)) begin
         seg = int'((a - 64'hC_0000) / 16384);
         if (wr) return m_attr[2*seg+1] ? 0 : 2;
         else    return m_attr[2*seg]   ? 0 : 2;
      end
      if (a < MB) return 0;
      if (a >= G4) return (mbn < eff) ? 0 : 1;
      if (a >= G4 - 2*MB) return 2;
      if (a >= G4 - 20*MB && a < G4 - 20*MB + 65536) return 3;
      if (m_hole && mbn == 15) return 1;
      return (mbn < eff) ? 0 : 1;
   endfunction

   function automatic bit model_sup(longint a, bit pci);
      int seg;
      if (!pci || !in_shadow(a)) return 0;
      seg = int'((a - 64'hC_0000) / 16384);
      return (m_attr[2*seg+1 -: 2] != 2'b00);
   endfunction

   task automatic check(string tag);
      checks++;
      if (out_valid !== exp_v || out_tgt !== exp_tgt || out_suppress !== exp_sup) begin
         errors++;
         $display("FAIL %s: got valid=%0b tgt=%b sup=%0b, expected valid=%0b tgt=%b sup=%0b",
                  tag, out_valid, out_tgt, out_suppress, exp_v, exp_tgt, exp_sup);
      end
   endtask

   // called at a falling edge; result checked at the next falling edge
   task automatic cyc(bit v, longint a, bit wr, bit pci, bit we, bit sel,
                      bit [CW-1:0] wd, string tag);
      in_valid = v; in_addr = a[AW-1:0]; in_write = wr; in_from_pci = pci;
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      exp_v   = v;
      exp_tgt = v ? (4'b0001 << model_tgt(a, wr)) : 4'b0000;
      exp_sup = v && model_sup(a, pci);
      if (we) begin
         if (sel) begin m_hole = wd[0]; m_smram = wd[1]; end
         else m_attr = wd;
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic tx(longint a, bit wr, bit pci, string tag);
      cyc(1, a, wr, pci, 0, 0, '0, tag);
   endtask

   task automatic cfgw(bit sel, bit [CW-1:0] wd, string tag);
      cyc(0, 0, 0, 0, 1, sel, wd, tag);
   endtask

   initial begin
      top_mb = 16'd1024;
      repeat (3) @(negedge clk);
      exp_v = 0; exp_tgt = '0; exp_sup = 0;
      check("R1 reset");
      rst_n = 1'b1;

      // R10: reset values (all ROM attributes, hole off)
      tx(64'hC_4000, 0, 0, "R10 reset attr read");
      tx(64'hC_4000, 1, 0, "R10 reset attr write");
      tx(15*MB + 64'h8_0000, 0, 0, "R10 hole off after reset");

      // R2: DRAM / PCI split
      tx(64'h1000, 0, 0, "R2 low memory");
      tx(64'hB_FFFF, 1, 0, "R2 below shadow area");
      tx(500*MB, 0, 0, "R2 mid DRAM");
      tx(1024*MB - 1, 0, 0, "R2 last DRAM byte");
      tx(1024*MB, 0, 0, "R2 first byte above top");
      tx(5*GB, 1, 0, "R2 above 4G above top");

      // R3: clamp of the top setting
      top_mb = 16'd16383;
      tx(12*GB - 1, 0, 0, "R3 last byte below clamped top");
      tx(12*GB, 0, 0, "R3 clamped top");
      top_mb = 16'd8192;
      tx(6*GB, 0, 0, "R3 above 4G within top");
      tx(8*GB, 0, 0, "R3 at unclamped top");

      // R4: extended SMRAM limit
      top_mb = 16'd1024;
      cfgw(1, 32'h2, "R4 set smram");
      tx(256*MB - 1, 0, 0, "R4 below 256MB");
      tx(256*MB, 0, 0, "R4 at 256MB");
      tx(600*MB, 1, 0, "R4 above 256MB");
      top_mb = 16'd100;
      tx(150*MB, 0, 0, "R4 smaller top wins");
      top_mb = 16'd1024;
      cfgw(1, 32'h0, "R4 clear smram");
      tx(600*MB, 0, 0, "R4 after clear");

      // R5: 15MB hole
      cfgw(1, 32'h1, "R5 set hole");
      tx(15*MB, 0, 0, "R5 hole start");
      tx(16*MB - 1, 1, 0, "R5 hole end");
      tx(15*MB - 1, 0, 0, "R5 below hole");
      tx(16*MB, 0, 0, "R5 above hole");

      // R6: firmware ROM window
      tx(G4 - 1, 0, 0, "R6 last byte below 4G");
      tx(G4 - 2*MB, 0, 0, "R6 window start");
      top_mb = 16'd16383;
      tx(G4 - 2*MB - 1, 0, 0, "R6 just below window, big top");
      tx(G4 - 2*MB + 64'h100, 1, 0, "R6 window wins over DRAM");
      tx(G4, 0, 0, "R6 4G is DRAM with big top");

      // R7: interrupt-controller window
      tx(G4 - 20*MB, 0, 0, "R7 window start, big top");
      top_mb = 16'd1024;
      tx(G4 - 20*MB + 65535, 1, 0, "R7 window end");
      tx(G4 - 20*MB + 65536, 0, 0, "R7 after window");
      tx(G4 - 20*MB - 1, 0, 0, "R7 before window");

      // R8: per-segment attributes
      cfgw(0, 32'h4000_0039, "R8 load attributes");
      tx(64'hC_0000, 0, 0, "R8 seg0 01 read");
      tx(64'hC_3FFF, 1, 0, "R8 seg0 01 write");
      tx(64'hC_4000, 0, 0, "R8 seg1 10 read");
      tx(64'hC_4000, 1, 0, "R8 seg1 10 write");
      tx(64'hC_8000, 0, 0, "R8 seg2 11 read");
      tx(64'hC_BFFF, 1, 0, "R8 seg2 11 write");
      tx(64'hC_C000, 0, 0, "R8 seg3 00 read");
      tx(64'hF_FFFF, 0, 0, "R8 seg15 01 read");
      tx(64'hF_C000, 1, 0, "R8 seg15 01 write");
      tx(64'h10_0000, 0, 0, "R8 first byte past area");

      // R9: suppression
      tx(64'hC_0000, 0, 1, "R9 pci read shadowed seg0");
      tx(64'hC_4000, 1, 1, "R9 pci write shadowed seg1");
      tx(64'hC_C000, 1, 1, "R9 pci unshadowed seg3");
      tx(64'hC_8000, 0, 0, "R9 cpu shadowed seg2");
      tx(64'h20_0000, 0, 1, "R9 pci outside area");

      // R10: same-cycle write uses old attribute
      cyc(1, 64'hC_8000, 0, 0, 1, 0, 32'h0, "R10 write and access same cycle");
      tx(64'hC_8000, 0, 0, "R10 new attribute next cycle");

      // R1: idle cycle with a live address
      cyc(0, G4 - 1, 0, 1, 0, 0, '0, "R1 idle");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         longint a;
         int k;
         k = $urandom_range(0, 7);
         case (k)
            0: a = longint'($urandom_range(0, 32'hB_FFFF));
            1: a = 64'hC_0000 + longint'($urandom_range(0, 32'h3_FFFF));
            2: a = 14*MB + longint'($urandom_range(0, 32'h30_0000));
            3: a = longint'(top_mb) * MB - 64'h800 + longint'($urandom_range(0, 32'hFFF));
            4: a = G4 - 32*MB + longint'($urandom_range(0, 32'h1FF_FFFF));
            5: a = G4 + (longint'($urandom) << 4);
            6: a = G4 - 20*MB - 64'h80 + longint'($urandom_range(0, 32'h1_0100));
            default: a = (longint'($urandom) << 4) | longint'($urandom_range(0, 15));
         endcase
         a = a & 64'hF_FFFF_FFFF;
         if ($urandom_range(0, 15) == 0) begin
            case ($urandom_range(0, 3))
               0: top_mb = 16'd1024;
               1: top_mb = 16'd16383;
               2: top_mb = TW'($urandom_range(0, 12500));
               default: top_mb = 16'd200;
            endcase
         end
         if ($urandom_range(0, 19) == 0)
            cyc($urandom_range(0, 1), a, $urandom_range(0, 1), $urandom_range(0, 1),
                1, $urandom_range(0, 1), $urandom, "R1 random with config");
         else
            cyc($urandom_range(0, 7) != 0, a, $urandom_range(0, 1), $urandom_range(0, 1),
                0, 0, '0, "R1 random");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule